// File: doc/BRIEF.md
# Configuration Header Ratio Detector

This block listens to a stream of 32-bit configuration-image words and works out which clock-to-data ratio the loader must use for that image. It does not change the stream. It counts the position of each accepted word from the start-of-image marker and reads two header flags at two fixed positions.

The first flag, at word 69, says whether the image is encrypted. The second, at word 229, says whether it is compressed. When word 229 arrives, the two flags are combined with the selected configuration width (16 or 32 bits) to form a 2-bit ratio code. A valid strobe is raised with the code. If the stream ends before word 229 has been seen, the block raises an error flag instead.

The block never applies backpressure, so it can sit beside the real consumer of the stream.

Top module: `hdr_ratio_detect`

## Requirements
- R1: The word that carries `word_sop` with `word_valid` is index 0, and each later accepted word increments the index. Words accepted before any start marker are ignored. `ratio_valid` rises in the cycle after word 229 is accepted, and not earlier.
- R2: The image counts as encrypted when bits [3:2] of word 69 are not 00. Any of 01, 10 or 11 counts.
- R3: The image counts as compressed when bit 1 of word 229 is 0.
- R4: Ratio code encoding is 00 = x1, 01 = x2, 10 = x4, 11 = x8. An image that is neither encrypted nor compressed gives 00 at both widths.
- R5: With `cfg_wide` = 0 (16-bit) sampled on the word-229 cycle, a compressed image gives 10 and an encrypted-only image gives 01.
- R6: With `cfg_wide` = 1 (32-bit) sampled on the word-229 cycle, a compressed image gives 11 and an encrypted-only image gives 10.
- R7: If `word_eop` arrives on an accepted word with index below 229, `hdr_error` rises in the next cycle and `ratio_valid` stays low. An `word_eop` on word 229 itself yields a normal result. `ratio_valid` and `hdr_error` are never high together.
- R8: Once valid, `ratio_code` and `ratio_valid` hold until the next start marker is accepted. Later words, later `cfg_wide` changes and the index counter (which saturates at 230) do not disturb them.
- R9: `word_ready` is always 1.
- R10: An accepted start marker clears `ratio_valid` and `hdr_error` in the next cycle and restarts indexing, even part-way through a header.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| word_valid | input | 1 | A stream word is present |
| word_data | input | 32 | Stream word |
| word_sop | input | 1 | Word is the first of an image |
| word_eop | input | 1 | Word is the last of the stream |
| cfg_wide | input | 1 | 1 = 32-bit configuration width, 0 = 16-bit |
| word_ready | output | 1 | Always high; the block never stalls the stream |
| ratio_code | output | 2 | Clock-to-data ratio code |
| ratio_valid | output | 1 | `ratio_code` is valid for the current image |
| hdr_error | output | 1 | Stream ended before the header was complete |

## Verification
Wrong internal state shows up at the ports in specific ways:
- An index that is off by one samples the wrong word. Its damage is visible one cycle after word 229, as a wrong code or as `ratio_valid` rising a word early or late.
- A stale encryption flag from an earlier image shows as a wrong code in the next plain image.
- A counter that does not saturate, or a capture that stays open, shows as `ratio_code` changing during trailing words.
- A missed restart shows as `ratio_valid` or `hdr_error` still high the cycle after a new start marker.

// File: rtl/hdr_ratio_pkg.sv
package hdr_ratio_pkg;

  localparam int unsigned HDR_WORD_W  = 32;
  localparam int unsigned HDR_ENC_IDX = 69;
  localparam int unsigned HDR_CMP_IDX = 229;
  localparam int unsigned HDR_ENC_LSB = 2;
  localparam int unsigned HDR_ENC_W   = 2;
  localparam int unsigned HDR_CMP_BIT = 1;

  typedef enum logic [1:0] {
    RATIO_X1 = 2'b00,
    RATIO_X2 = 2'b01,
    RATIO_X4 = 2'b10,
    RATIO_X8 = 2'b11
  } ratio_e;

  // Encryption mode field: any nonzero mode means encrypted.
  function automatic logic enc_decode(input logic [HDR_ENC_W-1:0] field);
    return |field;
  endfunction

  // Decompression bit: low means the image is compressed.
  function automatic logic cmp_decode(input logic dbit);
    return ~dbit;
  endfunction

  // Base code from the flags, stepped once more for the wide bus.
  function automatic ratio_e ratio_calc(input logic wide,
                                        input logic enc,
                                        input logic cmp);
    logic [1:0] base;
    if (!enc && !cmp) return RATIO_X1;
    base = cmp ? 2'(RATIO_X4) : 2'(RATIO_X2);
    if (wide) base = base + 2'd1;
    return ratio_e'(base);
  endfunction

endpackage

// File: rtl/hdr_word_index.sv
module hdr_word_index #(
  parameter int unsigned ENC_IDX = 69,
  parameter int unsigned CMP_IDX = 229,
  localparam int unsigned DONE_IDX = CMP_IDX + 1,
  localparam int unsigned IDX_W = $clog2(DONE_IDX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             word_valid,
  input  logic             word_sop,
  input  logic             word_eop,
  output logic             restart,
  output logic             hit_enc,
  output logic             hit_cmp,
  output logic             early_end,
  output logic [IDX_W-1:0] idx_q
);

  logic             active_q;
  logic             take;
  logic [IDX_W-1:0] cur_idx;

  // Words are taken only inside an image; the start marker opens one.
  assign take      = word_valid && (word_sop || active_q);
  assign cur_idx   = word_sop ? '0 : idx_q;
  assign restart   = word_valid && word_sop;
  assign hit_enc   = take && (cur_idx == IDX_W'(ENC_IDX));
  assign hit_cmp   = take && (cur_idx == IDX_W'(CMP_IDX));
  assign early_end = take && word_eop && (cur_idx < IDX_W'(CMP_IDX));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      idx_q    <= IDX_W'(DONE_IDX);
    end else if (take) begin
      if (hit_cmp || early_end) begin
        active_q <= 1'b0;
        idx_q    <= IDX_W'(DONE_IDX);
      end else begin
        active_q <= 1'b1;
        idx_q    <= cur_idx + 1'b1;
      end
    end
  end

endmodule

// File: rtl/hdr_flag_capture.sv
module hdr_flag_capture
  import hdr_ratio_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 restart,
  input  logic                 hit_enc,
  input  logic [HDR_ENC_W-1:0] enc_field,
  output logic                 enc_flag
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enc_flag <= 1'b0;
    end else if (hit_enc) begin
      enc_flag <= enc_decode(enc_field);
    end else if (restart) begin
      enc_flag <= 1'b0;
    end
  end

endmodule

// File: rtl/hdr_ratio_result.sv
module hdr_ratio_result
  import hdr_ratio_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic       hit_cmp,
  input  logic       early_end,
  input  logic       cfg_wide,
  input  logic       enc_flag,
  input  logic       cmp_now,
  output logic [1:0] ratio_code,
  output logic       ratio_valid,
  output logic       hdr_error
);

  ratio_e next_code;
  assign next_code = ratio_calc(cfg_wide, enc_flag, cmp_now);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ratio_code  <= 2'(RATIO_X1);
      ratio_valid <= 1'b0;
      hdr_error   <= 1'b0;
    end else begin
      if (restart) begin
        ratio_code  <= 2'(RATIO_X1);
        ratio_valid <= 1'b0;
        hdr_error   <= 1'b0;
      end
      if (hit_cmp) begin
        ratio_code  <= 2'(next_code);
        ratio_valid <= 1'b1;
      end
      if (early_end) begin
        hdr_error <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/hdr_ratio_detect.sv
module hdr_ratio_detect
  import hdr_ratio_pkg::*;
#(
  parameter int unsigned ENC_IDX = HDR_ENC_IDX,
  parameter int unsigned CMP_IDX = HDR_CMP_IDX,
  localparam int unsigned IDX_W = $clog2(CMP_IDX + 2)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  word_valid,
  input  logic [HDR_WORD_W-1:0] word_data,
  input  logic                  word_sop,
  input  logic                  word_eop,
  input  logic                  cfg_wide,
  output logic                  word_ready,
  output logic [1:0]            ratio_code,
  output logic                  ratio_valid,
  output logic                  hdr_error
);

  // Internal events, named for the checker.
  logic             restart;
  logic             hit_enc;
  logic             hit_cmp;
  logic             early_end;
  logic             enc_flag;
  logic             cmp_now;
  logic [IDX_W-1:0] idx_q;

  assign word_ready = 1'b1;
  assign cmp_now    = cmp_decode(word_data[HDR_CMP_BIT]);

  hdr_word_index #(
    .ENC_IDX (ENC_IDX),
    .CMP_IDX (CMP_IDX)
  ) u_index (
    .clk        (clk),
    .rst_n      (rst_n),
    .word_valid (word_valid),
    .word_sop   (word_sop),
    .word_eop   (word_eop),
    .restart    (restart),
    .hit_enc    (hit_enc),
    .hit_cmp    (hit_cmp),
    .early_end  (early_end),
    .idx_q      (idx_q)
  );

  hdr_flag_capture u_capture (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (restart),
    .hit_enc   (hit_enc),
    .enc_field (word_data[HDR_ENC_LSB +: HDR_ENC_W]),
    .enc_flag  (enc_flag)
  );

  hdr_ratio_result u_result (
    .clk         (clk),
    .rst_n       (rst_n),
    .restart     (restart),
    .hit_cmp     (hit_cmp),
    .early_end   (early_end),
    .cfg_wide    (cfg_wide),
    .enc_flag    (enc_flag),
    .cmp_now     (cmp_now),
    .ratio_code  (ratio_code),
    .ratio_valid (ratio_valid),
    .hdr_error   (hdr_error)
  );

endmodule

// File: rtl/hdr_ratio_detect_chk.sv
module hdr_ratio_detect_chk #(
  parameter int unsigned CMP_IDX = 229,
  localparam int unsigned IDX_W = $clog2(CMP_IDX + 2)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             word_valid,
  input logic             word_sop,
  input logic             word_eop,
  input logic             word_ready,
  input logic [1:0]       ratio_code,
  input logic             ratio_valid,
  input logic             hdr_error,
  input logic             hit_cmp,
  input logic             early_end,
  input logic             enc_flag,
  input logic             cmp_now,
  input logic [IDX_W-1:0] idx_q
);

  AST_READY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    word_ready); // R9

  AST_VALID_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    hit_cmp |=> ratio_valid); // R1

  AST_VALID_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ratio_valid) |-> $past(hit_cmp)); // R1

  AST_PLAIN_X1: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_cmp && !enc_flag && !cmp_now) |=> (ratio_code == 2'b00)); // R4

  AST_SHORT_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    early_end |=> (hdr_error && !ratio_valid)); // R7

  AST_NOT_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    !(ratio_valid && hdr_error)); // R7

  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio_valid && !(word_valid && word_sop)) |=> (ratio_valid && $stable(ratio_code))); // R8

  AST_IDX_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= IDX_W'(CMP_IDX + 1)); // R8

  AST_RESTART_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && word_sop && !word_eop) |=> (!ratio_valid && !hdr_error)); // R10

endmodule

bind hdr_ratio_detect hdr_ratio_detect_chk #(.CMP_IDX(CMP_IDX)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .word_valid  (word_valid),
  .word_sop    (word_sop),
  .word_eop    (word_eop),
  .word_ready  (word_ready),
  .ratio_code  (ratio_code),
  .ratio_valid (ratio_valid),
  .hdr_error   (hdr_error),
  .hit_cmp     (hit_cmp),
  .early_end   (early_end),
  .enc_flag    (enc_flag),
  .cmp_now     (cmp_now),
  .idx_q       (idx_q)
);

// File: tb/hdr_ratio_detect_tb.sv
`timescale 1ns/1ps
module hdr_ratio_detect_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        word_valid = 1'b0;
  logic [31:0] word_data = '0;
  logic        word_sop = 1'b0;
  logic        word_eop = 1'b0;
  logic        cfg_wide = 1'b0;
  logic        word_ready;
  logic [1:0]  ratio_code;
  logic        ratio_valid;
  logic        hdr_error;

  int n_checks = 0;
  int n_errors = 0;

  always #2.5 clk = ~clk;

  hdr_ratio_detect u_dut (
    .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word_data(word_data),
    .word_sop(word_sop), .word_eop(word_eop), .cfg_wide(cfg_wide),
    .word_ready(word_ready), .ratio_code(ratio_code),
    .ratio_valid(ratio_valid), .hdr_error(hdr_error)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected code from the requirements: pick the multiplier, then its log2.
  function automatic logic [1:0] exp_code(input logic [1:0] encf, input bit cmpb, input bit wide);
    int mult;
    mult = 1;
    if (cmpb == 1'b0) mult = wide ? 8 : 4;
    else if (encf != 2'b00) mult = wide ? 4 : 2;
    case (mult)
      1: return 2'b00;
      2: return 2'b01;
      4: return 2'b10;
      default: return 2'b11;
    endcase
  endfunction

  // Junk-filled word with the two header fields placed at their positions.
  function automatic logic [31:0] word_of(input int i, input logic [1:0] encf, input bit cmpb);
    logic [31:0] d;
    d = {i[15:0] ^ 16'h5A3C, ~i[15:0]};
    if (i == 69) d[3:2] = encf;
    if (i == 229) d[1] = cmpb;
    return d;
  endfunction

  // Drive one word at a falling edge; returns at the next falling edge.
  task automatic put(input logic [31:0] d, input bit sop, input bit eop);
    word_valid = 1'b1; word_data = d; word_sop = sop; word_eop = eop;
    @(negedge clk);
    word_valid = 1'b0; word_sop = 1'b0; word_eop = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      word_valid = 1'b0; word_data = 32'hFFFF_FFFF; word_sop = 1'b0; word_eop = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic send_image(input int n, input logic [1:0] encf, input bit cmpb,
                            input bit wide, input bit with_eop, input bit gaps);
    cfg_wide = wide;
    for (int i = 0; i < n; i++) begin
      put(word_of(i, encf, cmpb), i == 0, with_eop && (i == n - 1));
      if (gaps && (i % 3 == 0)) idle(1);
    end
    idle(1);
  endtask

  task automatic t_reset();
    chk("R9 ready after reset", word_ready, 1);
    chk("R1 no valid after reset", ratio_valid, 0);
    chk("R7 no error after reset", hdr_error, 0);
  endtask

  task automatic t_plain();
    send_image(230, 2'b00, 1'b1, 1'b0, 1'b1, 1'b0);
    chk("R4 plain 16-bit valid", ratio_valid, 1);
    chk("R4 plain 16-bit code", ratio_code, exp_code(2'b00, 1'b1, 1'b0));
    send_image(240, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0);
    chk("R4 plain 32-bit code", ratio_code, exp_code(2'b00, 1'b1, 1'b1));
  endtask

  task automatic t_narrow();
    send_image(230, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R5 R3 compressed 16-bit", ratio_code, exp_code(2'b00, 1'b0, 1'b0));
    send_image(230, 2'b01, 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R5 R2 enc=01 16-bit", ratio_code, exp_code(2'b01, 1'b1, 1'b0));
    send_image(230, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R5 enc+cmp 16-bit", ratio_code, exp_code(2'b11, 1'b0, 1'b0));
  endtask

  task automatic t_wide();
    send_image(230, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R6 R3 compressed 32-bit", ratio_code, exp_code(2'b00, 1'b0, 1'b1));
    send_image(230, 2'b10, 1'b1, 1'b1, 1'b0, 1'b1);
    chk("R6 R2 enc=10 32-bit gaps", ratio_code, exp_code(2'b10, 1'b1, 1'b1));
    send_image(230, 2'b11, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R6 enc+cmp 32-bit", ratio_code, exp_code(2'b11, 1'b0, 1'b1));
  endtask

  task automatic t_latency();
    cfg_wide = 1'b0;
    for (int i = 0; i < 229; i++) put(word_of(i, 2'b01, 1'b1), i == 0, 1'b0);
    chk("R1 no valid before word 229", ratio_valid, 0);
    put(word_of(229, 2'b01, 1'b1), 1'b0, 1'b0);
    chk("R1 valid after word 229", ratio_valid, 1);
    chk("R1 code after word 229", ratio_code, exp_code(2'b01, 1'b1, 1'b0));
    idle(1);
  endtask

  task automatic t_short();
    send_image(101, 2'b11, 1'b0, 1'b1, 1'b1, 1'b0);
    chk("R7 short stream error", hdr_error, 1);
    chk("R7 short stream no valid", ratio_valid, 0);
    send_image(230, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R7 end on word 229 no error", hdr_error, 0);
    chk("R7 end on word 229 valid", ratio_valid, 1);
  endtask

  task automatic t_hold();
    logic [1:0] e;
    e = exp_code(2'b10, 1'b0, 1'b0);
    send_image(230, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0);
    cfg_wide = 1'b1;
    for (int i = 230; i < 700; i++) put(word_of(i - 460, 2'b00, 1'b1), 1'b0, i == 699);
    idle(2);
    chk("R8 code held over trailing words", ratio_code, e);
    chk("R8 valid held", ratio_valid, 1);
    chk("R8 no error from late eop", hdr_error, 0);
  endtask

  task automatic t_no_sop();
    put(32'h0, 1'b1, 1'b1);
    chk("R7 sop+eop single word error", hdr_error, 1);
    for (int i = 0; i < 300; i++) put(word_of(i, 2'b11, 1'b0), 1'b0, 1'b0);
    chk("R1 words without sop ignored valid", ratio_valid, 0);
    chk("R1 words without sop ignored error", hdr_error, 1);
  endtask

  task automatic t_restart();
    send_image(230, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0);
    cfg_wide = 1'b0;
    put(word_of(0, 2'b11, 1'b0), 1'b1, 1'b0);
    chk("R10 sop clears valid", ratio_valid, 0);
    chk("R10 sop clears error", hdr_error, 0);
    for (int i = 1; i < 120; i++) put(word_of(i, 2'b11, 1'b0), 1'b0, 1'b0);
    send_image(230, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R10 restarted plain image x1", ratio_code, exp_code(2'b00, 1'b1, 1'b0));
    chk("R10 restarted image valid", ratio_valid, 1);
  endtask

  initial begin
    #1000000;
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    idle(4);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_plain();
    t_narrow();
    t_wide();
    t_latency();
    t_short();
    t_hold();
    t_no_sop();
    t_restart();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule